// File: doc/BRIEF.md
# UART Channel Line Mode Router

This block sits between one UART channel's receiver, its transmitter and the two serial pins. A 2-bit mode field picks one of four modes:

- **Normal**: the transmitter and receiver run independently.
- **Echo**: incoming data is re-clocked onto the outgoing pin.
- **Local loopback**: the transmitter feeds the receiver internally.
- **Remote loopback**: incoming data is echoed, and nothing is delivered to the host.

In each mode the router steers the serial lines and picks which bit-rate tick each shift engine uses. It also masks the transmitter status flags, the host write strobe, the receive push strobe and the error bits.

A mode change acts in the same cycle, even in the middle of a character, with one exception. If a stop bit has just been sampled while an echo mode is active and the transmitter is enabled, the router latches that echo mode. It keeps that mode until the transmitter reports that the stop bit has been fully sent. Baud generation, shift registers and FIFOs live outside this block.

Top module: `uart_mode_router`

## Requirements
- R1: In mode 00 (normal), `txd_pin_o` follows `tx_ser_i` and `rx_ser_o` follows `rxd_pin_i`. Each tick output follows its own tick input. The status flags, `cpu_tx_wr_o`, `rx_push_o` and `rx_err_o` pass unchanged, and `chk_en_o` is 1.
- R2: In mode 01 (echo) with `rx_en_i` high, `txd_pin_o` equals the value `rxd_pin_i` had at the previous rising clock edge. A held low level (a break) is therefore echoed for as long as it lasts. `tx_tick_o` follows `rx_tick_i`, and the receiver still sees `rxd_pin_i`.
- R3: In mode 01, `tx_room_o`, `tx_idle_o` and `cpu_tx_wr_o` are 0. `rx_push_o` and `rx_err_o` pass unchanged, and `chk_en_o` is 1.
- R4: In mode 10 (local loopback), `txd_pin_o` is 1 and `rx_ser_o` follows `tx_ser_i`, so `rxd_pin_i` has no effect. `rx_tick_o` follows `tx_tick_i`. The flags and strobes pass unchanged.
- R5: In mode 11 (remote loopback), `txd_pin_o` echoes as in R2 and `tx_tick_o` follows `rx_tick_i`. `rx_push_o` is 0, `rx_err_o` is 0 and `chk_en_o` is 0. `tx_room_o`, `tx_idle_o` and `cpu_tx_wr_o` are 0.
- R6: When the enable that a routed line needs is low, that line idles at 1. This covers `txd_pin_o` in modes 01 and 11 with `rx_en_i` low, and `rx_ser_o` in mode 10 with `tx_en_i` low.
- R7: While no deferred exit is pending, every output follows a new `mode_i` value combinationally, in the same cycle.
- R8: A `stop_sampled_i` pulse in mode 01 or 11 with `tx_en_i` high latches that mode from the next cycle on, whatever `mode_i` is. The latch releases in the cycle after a `stop_done_i` pulse. With `tx_en_i` low, or outside the echo modes, the pulse is ignored.
- R9: If `stop_sampled_i` and `stop_done_i` arrive in the same cycle while a latch can be set, the latch is set (or stays set).
- R10: During reset the deferred-exit latch is clear and the re-clocked echo level is 1, so `txd_pin_o` is 1 in modes 01 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mode field: 00 normal, 01 echo, 10 local loopback, 11 remote loopback |
| rx_en_i | input | 1 | Receiver enable |
| tx_en_i | input | 1 | Transmitter enable |
| rxd_pin_i | input | 1 | Serial input pin |
| txd_pin_o | output | 1 | Serial output pin |
| tx_ser_i | input | 1 | Transmitter shift output |
| rx_ser_o | output | 1 | Serial line delivered to the receiver |
| rx_tick_i | input | 1 | Receive bit-rate tick |
| tx_tick_i | input | 1 | Transmit bit-rate tick |
| rx_tick_o | output | 1 | Tick delivered to the receiver |
| tx_tick_o | output | 1 | Tick delivered to the transmitter |
| stop_sampled_i | input | 1 | Receiver has just sampled a stop bit |
| stop_done_i | input | 1 | Transmitter has finished sending a stop bit |
| tx_room_raw_i | input | 1 | Transmit holding stage has room |
| tx_idle_raw_i | input | 1 | Transmitter fully idle |
| tx_room_o | output | 1 | Masked room flag |
| tx_idle_o | output | 1 | Masked idle flag |
| cpu_tx_wr_i | input | 1 | Host write strobe to the transmitter |
| cpu_tx_wr_o | output | 1 | Masked write strobe |
| rx_push_i | input | 1 | Receiver delivers a character |
| rx_push_o | output | 1 | Masked delivery strobe |
| rx_err_i | input | ERR_W | Receiver error bits |
| rx_err_o | output | ERR_W | Masked error bits |
| chk_en_o | output | 1 | Parity and framing check enable |

## Verification
Two things can land in the same cycle: the receiver reports a sampled stop bit, and the transmitter reports a finished stop bit. The bench raises both strobes together while echo is latched and `mode_i` already reads normal. It then requires the echo masking to persist in the following cycle, which shows that setting the latch wins. A second collision is provoked by changing `mode_i` in the very cycle of the sample. That case must not latch, because the mode in force at the sample decides.

// File: rtl/umr_pkg.sv
package umr_pkg;

   typedef enum logic [1:0] {
      UMR_NORMAL = 2'b00,
      UMR_ECHO   = 2'b01,
      UMR_LOCAL  = 2'b10,
      UMR_REMOTE = 2'b11
   } umr_mode_e;

   function automatic logic umr_is_echo(umr_mode_e m);
      return (m == UMR_ECHO) || (m == UMR_REMOTE);
   endfunction

endpackage

// File: rtl/umr_exit_ctl.sv
module umr_exit_ctl
   import umr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       tx_en_i,
   input  logic       stop_sampled_i,
   input  logic       stop_done_i,
   output umr_mode_e  eff_mode_o,
   output logic       hold_o
);

   logic      hold_q;
   umr_mode_e held_q;
   logic      arm;

   // Effective mode: a pending deferred exit pins the latched echo mode.
   assign eff_mode_o = hold_q ? held_q : umr_mode_e'(mode_i);
   assign hold_o     = hold_q;
   assign arm        = stop_sampled_i & tx_en_i & umr_is_echo(eff_mode_o);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         held_q <= UMR_NORMAL;
      end else if (arm) begin
         hold_q <= 1'b1;
         held_q <= eff_mode_o;
      end else if (stop_done_i) begin
         hold_q <= 1'b0;
      end
   end

   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && stop_done_i && !stop_sampled_i) |=> !hold_o);   // R8
   AST_HOLD_ECHO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      hold_o |-> umr_is_echo(eff_mode_o));                        // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_sampled_i && stop_done_i && tx_en_i && umr_is_echo(eff_mode_o)) |=> hold_o); // R9
   AST_NO_ARM_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_o && !tx_en_i) |=> !hold_o);                          // R8

endmodule

// File: rtl/umr_line_route.sv
module umr_line_route
   import umr_pkg::*;
#(
   parameter int RECLK_STAGES = 1,
   parameter bit IDLE_LEVEL   = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  umr_mode_e eff_mode_i,
   input  logic      rx_en_i,
   input  logic      tx_en_i,
   input  logic      rxd_pin_i,
   input  logic      tx_ser_i,
   output logic      txd_pin_o,
   output logic      rx_ser_o
);

   logic rxd_rc;

   // Re-clocking of the incoming line; variant chosen by parameter.
   if (RECLK_STAGES == 1) begin : g_reclk_one
      logic s0_q;
      always_ff @(posedge clk) begin
         if (!rst_n) s0_q <= IDLE_LEVEL;
         else        s0_q <= rxd_pin_i;
      end
      assign rxd_rc = s0_q;
   end else begin : g_reclk_two
      logic [1:0] s_q;
      always_ff @(posedge clk) begin
         if (!rst_n) s_q <= {2{IDLE_LEVEL}};
         else        s_q <= {s_q[0], rxd_pin_i};
      end
      assign rxd_rc = s_q[1];
   end

   always_comb begin
      unique case (eff_mode_i)
         UMR_ECHO, UMR_REMOTE: begin
            txd_pin_o = rx_en_i ? rxd_rc : IDLE_LEVEL;
            rx_ser_o  = rxd_pin_i;
         end
         UMR_LOCAL: begin
            txd_pin_o = IDLE_LEVEL;
            rx_ser_o  = tx_en_i ? tx_ser_i : IDLE_LEVEL;
         end
         default: begin
            txd_pin_o = tx_ser_i;
            rx_ser_o  = rxd_pin_i;
         end
      endcase
   end

   logic past_ok_q;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok_q <= 1'b0;
      else        past_ok_q <= 1'b1;
   end

   if (RECLK_STAGES == 1) begin : g_chk_one
      AST_ECHO_RECLK: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok_q && umr_is_echo(eff_mode_i) && rx_en_i) |-> (txd_pin_o == $past(rxd_pin_i))); // R2
   end
   AST_LOCAL_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_LOCAL) |-> (txd_pin_o == IDLE_LEVEL));     // R4
   AST_LOCAL_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_LOCAL && tx_en_i) |-> (rx_ser_o == tx_ser_i)); // R4
   AST_ECHO_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (umr_is_echo(eff_mode_i) && !rx_en_i) |-> (txd_pin_o == IDLE_LEVEL)); // R6

endmodule

// File: rtl/umr_tick_route.sv
module umr_tick_route
   import umr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  umr_mode_e eff_mode_i,
   input  logic      rx_tick_i,
   input  logic      tx_tick_i,
   output logic      rx_tick_o,
   output logic      tx_tick_o
);

   assign rx_tick_o = (eff_mode_i == UMR_LOCAL) ? tx_tick_i : rx_tick_i;
   assign tx_tick_o = umr_is_echo(eff_mode_i)   ? rx_tick_i : tx_tick_i;

   AST_ECHO_TX_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      umr_is_echo(eff_mode_i) |-> (tx_tick_o == rx_tick_i));       // R2
   AST_LOCAL_RX_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_LOCAL) |-> (rx_tick_o == tx_tick_i));     // R4
   AST_NORMAL_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_NORMAL) |-> (rx_tick_o == rx_tick_i && tx_tick_o == tx_tick_i)); // R1

endmodule

// File: rtl/umr_cpu_gate.sv
module umr_cpu_gate
   import umr_pkg::*;
#(
   parameter int ERR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  umr_mode_e        eff_mode_i,
   input  logic             tx_room_raw_i,
   input  logic             tx_idle_raw_i,
   input  logic             cpu_tx_wr_i,
   input  logic             rx_push_i,
   input  logic [ERR_W-1:0] rx_err_i,
   output logic             tx_room_o,
   output logic             tx_idle_o,
   output logic             cpu_tx_wr_o,
   output logic             rx_push_o,
   output logic [ERR_W-1:0] rx_err_o,
   output logic             chk_en_o
);

   logic tx_masked;
   logic rx_masked;

   assign tx_masked   = umr_is_echo(eff_mode_i);
   assign rx_masked   = (eff_mode_i == UMR_REMOTE);

   assign tx_room_o   = tx_room_raw_i & ~tx_masked;
   assign tx_idle_o   = tx_idle_raw_i & ~tx_masked;
   assign cpu_tx_wr_o = cpu_tx_wr_i   & ~tx_masked;
   assign rx_push_o   = rx_push_i     & ~rx_masked;
   assign rx_err_o    = rx_err_i      & {ERR_W{~rx_masked}};
   assign chk_en_o    = ~rx_masked;

   AST_TX_SIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      umr_is_echo(eff_mode_i) |-> (!tx_room_o && !tx_idle_o && !cpu_tx_wr_o)); // R3
   AST_REMOTE_NO_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_REMOTE) |-> (!rx_push_o && rx_err_o == '0 && !chk_en_o)); // R5
   AST_ECHO_RX_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode_i == UMR_ECHO) |-> (rx_push_o == rx_push_i && rx_err_o == rx_err_i && chk_en_o)); // R3

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
   import umr_pkg::*;
#(
   parameter int ERR_W        = 3,
   parameter int RECLK_STAGES = 1,
   parameter bit IDLE_LEVEL   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             rx_en_i,
   input  logic             tx_en_i,
   input  logic             rxd_pin_i,
   output logic             txd_pin_o,
   input  logic             tx_ser_i,
   output logic             rx_ser_o,
   input  logic             rx_tick_i,
   input  logic             tx_tick_i,
   output logic             rx_tick_o,
   output logic             tx_tick_o,
   input  logic             stop_sampled_i,
   input  logic             stop_done_i,
   input  logic             tx_room_raw_i,
   input  logic             tx_idle_raw_i,
   output logic             tx_room_o,
   output logic             tx_idle_o,
   input  logic             cpu_tx_wr_i,
   output logic             cpu_tx_wr_o,
   input  logic             rx_push_i,
   output logic             rx_push_o,
   input  logic [ERR_W-1:0] rx_err_i,
   output logic [ERR_W-1:0] rx_err_o,
   output logic             chk_en_o
);

   if (ERR_W < 1 || ERR_W > 16) begin : g_bad_err_w
      $error("uart_mode_router: ERR_W must lie in 1..16");
   end
   if (RECLK_STAGES < 1 || RECLK_STAGES > 2) begin : g_bad_reclk
      $error("uart_mode_router: RECLK_STAGES must be 1 or 2");
   end

   umr_mode_e eff_mode;
   logic      hold;

   umr_exit_ctl u_exit (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_i         (mode_i),
      .tx_en_i        (tx_en_i),
      .stop_sampled_i (stop_sampled_i),
      .stop_done_i    (stop_done_i),
      .eff_mode_o     (eff_mode),
      .hold_o         (hold)
   );

   umr_line_route #(
      .RECLK_STAGES (RECLK_STAGES),
      .IDLE_LEVEL   (IDLE_LEVEL)
   ) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_mode_i (eff_mode),
      .rx_en_i    (rx_en_i),
      .tx_en_i    (tx_en_i),
      .rxd_pin_i  (rxd_pin_i),
      .tx_ser_i   (tx_ser_i),
      .txd_pin_o  (txd_pin_o),
      .rx_ser_o   (rx_ser_o)
   );

   umr_tick_route u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff_mode_i (eff_mode),
      .rx_tick_i  (rx_tick_i),
      .tx_tick_i  (tx_tick_i),
      .rx_tick_o  (rx_tick_o),
      .tx_tick_o  (tx_tick_o)
   );

   umr_cpu_gate #(
      .ERR_W (ERR_W)
   ) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .eff_mode_i    (eff_mode),
      .tx_room_raw_i (tx_room_raw_i),
      .tx_idle_raw_i (tx_idle_raw_i),
      .cpu_tx_wr_i   (cpu_tx_wr_i),
      .rx_push_i     (rx_push_i),
      .rx_err_i      (rx_err_i),
      .tx_room_o     (tx_room_o),
      .tx_idle_o     (tx_idle_o),
      .cpu_tx_wr_o   (cpu_tx_wr_o),
      .rx_push_o     (rx_push_o),
      .rx_err_o      (rx_err_o),
      .chk_en_o      (chk_en_o)
   );

   AST_IMMEDIATE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> (eff_mode == umr_mode_e'(mode_i)));                  // R7
   AST_HOLD_PINS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (!tx_room_o && !tx_idle_o && tx_tick_o == rx_tick_i)); // R8

endmodule

// File: tb/uart_mode_router_tb.sv
module uart_mode_router_tb;

   localparam int EW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]    mode;
   logic          rx_en, tx_en, rxd, tx_ser, rt, tt, ss, sd, room, idle, wr, push;
   logic [EW-1:0] err;
   logic          txd, rx_ser, rto, tto, room_o, idle_o, wr_o, push_o, chk;
   logic [EW-1:0] err_o;

   uart_mode_router #(.ERR_W(EW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .rx_en_i(rx_en), .tx_en_i(tx_en),
      .rxd_pin_i(rxd), .txd_pin_o(txd), .tx_ser_i(tx_ser), .rx_ser_o(rx_ser),
      .rx_tick_i(rt), .tx_tick_i(tt), .rx_tick_o(rto), .tx_tick_o(tto),
      .stop_sampled_i(ss), .stop_done_i(sd), .tx_room_raw_i(room), .tx_idle_raw_i(idle),
      .tx_room_o(room_o), .tx_idle_o(idle_o), .cpu_tx_wr_i(wr), .cpu_tx_wr_o(wr_o),
      .rx_push_i(push), .rx_push_o(push_o), .rx_err_i(err), .rx_err_o(err_o), .chk_en_o(chk)
   );

   int vecs = 0;
   int bad  = 0;
   logic finished = 1'b0;

   // Level of the input pin at the most recent rising edge (one-cycle echo, R2).
   logic seen;
   always @(posedge clk) seen <= rst_n ? rxd : 1'b1;

   task automatic chk1(input string req, input logic act, input logic exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [12:0] model(input logic [1:0] m, input logic re, input logic te,
         input logic pin, input logic prev, input logic ts, input logic r_t, input logic t_t,
         input logic rm, input logic id, input logic w, input logic p, input logic [EW-1:0] e);
      logic echo, o_txd, o_rxs, o_rt, o_tt;
      echo  = (m == 2'b01) || (m == 2'b11);
      o_txd = (m == 2'b10) ? 1'b1 : (echo ? (re ? prev : 1'b1) : ts);
      o_rxs = (m == 2'b10) ? (te ? ts : 1'b1) : pin;
      o_rt  = (m == 2'b10) ? t_t : r_t;
      o_tt  = echo ? r_t : t_t;
      return {o_txd, o_rxs, o_rt, o_tt, rm & ~echo, id & ~echo, w & ~echo,
              p & (m != 2'b11), (m != 2'b11), e & {EW{m != 2'b11}}, 1'b0};
   endfunction

   function automatic logic [12:0] observed();
      return {txd, rx_ser, rto, tto, room_o, idle_o, wr_o, push_o, chk, err_o, 1'b0};
   endfunction

   task automatic drive_idle();
      ss = 0; sd = 0; rt = 0; tt = 0; room = 0; idle = 0; wr = 0; push = 0; err = '0;
      tx_ser = 0;
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      if (!finished) begin
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      mode = 2'b01; rx_en = 1; tx_en = 1; rxd = 0;
      drive_idle();
      // R10: reset state, echo mode with a low pin still drives the idle level.
      repeat (3) @(posedge clk);
      @(negedge clk); #5;
      chk1("R10 txd during reset", txd, 1'b1);
      mode = 2'b11; #1;
      chk1("R10 remote txd during reset", txd, 1'b1);
      @(negedge clk); rst_n = 1; rxd = 1; mode = 2'b00;

      // Sweep: every mode, enable and data combination. The mode changes
      // every vector, so outputs following at once covers R7.
      for (int v = 0; v < 16384; v++) begin
         logic [12:0] e, a;
         string tag;
         @(negedge clk);
         mode = v[1:0]; rx_en = v[2]; tx_en = v[3]; rxd = v[4] ^ v[0] ^ v[6];
         tx_ser = v[5]; rt = v[6]; tt = v[7]; room = v[8]; idle = v[9];
         wr = v[10]; push = v[11]; err = v[13:12];
         #5;
         e = model(mode, rx_en, tx_en, rxd, seen, tx_ser, rt, tt, room, idle, wr, push, err);
         a = observed();
         case (mode)
            2'b00: tag = "R1 R7";
            2'b01: tag = (rx_en ? "R2 R3" : "R6 R3");
            2'b10: tag = (tx_en ? "R4" : "R6 R4");
            default: tag = (rx_en ? "R5" : "R6 R5");
         endcase
         vecs++;
         if (a !== e) begin
            bad++;
            $display("FAIL %s: vector %0d got %b expected %b", tag, v, a, e);
         end
      end

      // R8: deferred exit from echo.
      @(negedge clk);
      drive_idle(); mode = 2'b01; rx_en = 1; tx_en = 1; room = 1; idle = 1; rt = 1; tt = 0;
      ss = 1; #5;
      chk1("R8 room masked at sample", room_o, 1'b0);
      @(negedge clk); ss = 0; mode = 2'b00; #5;
      chk1("R8 held room masked", room_o, 1'b0);
      chk1("R8 held tx tick from rx", tto, 1'b1);
      @(negedge clk); #5;
      chk1("R8 still held", idle_o, 1'b0);
      @(negedge clk); sd = 1; #5;
      chk1("R8 held in done cycle", room_o, 1'b0);
      @(negedge clk); sd = 0; #5;
      chk1("R8 released room", room_o, 1'b1);
      chk1("R8 released tx tick", tto, 1'b0);

      // R8: remote loopback latch keeps host delivery off.
      @(negedge clk); mode = 2'b11; push = 1; ss = 1; #5;
      chk1("R8 remote push masked", push_o, 1'b0);
      @(negedge clk); ss = 0; mode = 2'b00; #5;
      chk1("R8 remote held push", push_o, 1'b0);
      chk1("R8 remote held chk", chk, 1'b0);
      @(negedge clk); sd = 1;
      @(negedge clk); sd = 0; #5;
      chk1("R8 remote released push", push_o, 1'b1);

      // R8: transmitter disabled means no deferral.
      @(negedge clk); mode = 2'b01; tx_en = 0; ss = 1;
      @(negedge clk); ss = 0; mode = 2'b00; #5;
      chk1("R8 no hold with tx off", room_o, 1'b1);

      // R8: sample in the same cycle as leaving echo does not latch.
      @(negedge clk); tx_en = 1; mode = 2'b01;
      @(negedge clk); mode = 2'b00; ss = 1;
      @(negedge clk); ss = 0; #5;
      chk1("R8 sample with mode change no hold", room_o, 1'b1);

      // R9: sample and done strobes together keep the latch.
      @(negedge clk); mode = 2'b01; ss = 1;
      @(negedge clk); ss = 0; mode = 2'b00;
      @(negedge clk); ss = 1; sd = 1; mode = 2'b00;
      @(negedge clk); ss = 0; sd = 0; #5;
      chk1("R9 set wins over clear", room_o, 1'b0);
      @(negedge clk); sd = 1;
      @(negedge clk); sd = 0; #5;
      chk1("R9 released afterwards", room_o, 1'b1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

endmodule